// File: doc/BRIEF.md
# Packed Lane Narrow and Interleave Unit

This unit rearranges the lanes of 64-bit packed operands. It narrows lanes with clamping: 16-bit lanes become bytes and 32-bit lanes become 16-bit lanes. Each narrowing uses either the signed or the unsigned range of the destination lane. It also widens data by interleaving lanes from two operands. The lanes come from the lower 32 bits or the upper 32 bits of both operands, at 8-, 16- or 32-bit granularity.

A datapath presents two sources and an opcode together with a valid strobe. One clock later, the result appears on a registered output with its own valid flag. Opcodes outside the supported set produce a zero result and raise an error flag.

The operand is viewed as lanes, with lane 0 in the least significant bits. A design that feeds this unit only needs to know the opcode encoding and the lane placement rules below.

Top module: `lane_pack_unit`

## Requirements
- R1: `out_valid` equals the value `in_valid` had at the previous rising clock edge. While `rst_n` is low, `out_valid`, `out_err` and `out_data` are all zero, and they go to zero as soon as `rst_n` falls.
- R2: Opcode 0 (signed narrow of 16-bit lanes to bytes) clamps each 16-bit lane to -128..127. The four lanes of `src_a` fill result bytes 0..3 and the four lanes of `src_b` fill bytes 4..7, each in lane order.
- R3: Opcode 1 (unsigned narrow of 16-bit lanes to bytes) uses the same placement as R2 but clamps to 0..255, so a negative lane gives 0.
- R4: Opcode 2 (signed narrow of 32-bit lanes to 16 bits) clamps to -32768..32767. The two lanes of `src_a` fill result lanes 0..1 and the two lanes of `src_b` fill lanes 2..3.
- R5: Opcode 3 (unsigned narrow of 32-bit lanes to 16 bits) uses the placement of R4 and clamps to 0..65535.
- R6: Opcodes 4, 5 and 6 interleave bits 31:0 of the sources at 8-, 16- and 32-bit lanes respectively. Lane i of `src_a` goes to result lane 2i, and lane i of `src_b` goes to result lane 2i+1.
- R7: Opcodes 7, 8 and 9 interleave bits 63:32 of the sources at 8-, 16- and 32-bit lanes, with the same even/odd placement as R6.
- R8: An accepted opcode from 10 to 15 gives `out_data` of zero and `out_err` high for that one output cycle. Any supported opcode gives `out_err` low.
- R9: A cycle with `in_valid` low leaves `out_data` unchanged and drives `out_err` low one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| in_valid | input | 1 | Operands and opcode are presented this cycle |
| op | input | 4 | Operation select (encoding in R2 to R8) |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| out_valid | output | 1 | Result register holds a new result |
| out_data | output | 64 | Registered result |
| out_err | output | 1 | The accepted opcode was unsupported |

## Verification
Every result, the error flag and the valid flag of this unit are due exactly one rising edge after the inputs are presented. Holding and clearing follow the same one-edge rule. Asynchronous reset is the only effect that must be seen without waiting for an edge.

The bench drives inputs on the falling edge. Its behavioural model predicts that edge's outcome, and the bench compares all three outputs on the next falling edge, half a period after the register has loaded. For the mid-run reset, the outputs are sampled shortly after `rst_n` falls, with no clock edge in between.

// File: rtl/lps_pkg.sv
`timescale 1ns/1ps
package lps_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NRW_S16 = 4'd0,
    OP_NRW_U16 = 4'd1,
    OP_NRW_S32 = 4'd2,
    OP_NRW_U32 = 4'd3,
    OP_ILV_LO8 = 4'd4,
    OP_ILV_LO16 = 4'd5,
    OP_ILV_LO32 = 4'd6,
    OP_ILV_HI8 = 4'd7,
    OP_ILV_HI16 = 4'd8,
    OP_ILV_HI32 = 4'd9
  } lps_op_e;

  localparam logic [OP_W-1:0] OP_LAST_VALID = 4'd9;
endpackage

// File: rtl/lps_clamp.sv
`timescale 1ns/1ps
// Clamp one IN_W-bit two's-complement lane into OUT_W bits.
module lps_clamp #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 8
) (
  input  logic [IN_W-1:0]  v,
  input  logic             uns,
  output logic [OUT_W-1:0] q
);
  logic neg;
  logic s_fit;
  logic u_fit;

  assign neg   = v[IN_W-1];
  // Signed fit: all bits from the destination sign bit upward agree.
  assign s_fit = (v[IN_W-1:OUT_W-1] == '0) || (v[IN_W-1:OUT_W-1] == '1);
  assign u_fit = (v[IN_W-1:OUT_W] == '0);

  always_comb begin
    if (uns) begin
      if (neg)         q = '0;
      else if (!u_fit) q = '1;
      else             q = v[OUT_W-1:0];
    end else begin
      if (s_fit)       q = v[OUT_W-1:0];
      else if (neg)    q = {1'b1, {(OUT_W-1){1'b0}}};
      else             q = {1'b0, {(OUT_W-1){1'b1}}};
    end
  end
endmodule

// File: rtl/lps_narrow.sv
`timescale 1ns/1ps
// Narrow every IN_W lane of {b,a} to half width; a fills the low half.
module lps_narrow #(
  parameter int DATA_W = 64,
  parameter int IN_W   = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              uns,
  output logic [DATA_W-1:0] y
);
  localparam int OUT_W = IN_W / 2;
  localparam int NL    = DATA_W / IN_W;

  logic [2*NL-1:0][IN_W-1:0] lanes;
  assign lanes = {b, a};

  for (genvar i = 0; i < 2*NL; i++) begin : g_lane
    lps_clamp #(.IN_W(IN_W), .OUT_W(OUT_W)) u_clamp (
      .v   (lanes[i]),
      .uns (uns),
      .q   (y[i*OUT_W +: OUT_W])
    );
  end
endmodule

// File: rtl/lps_interleave.sv
`timescale 1ns/1ps
// Interleave one half of a and b: a to even lanes, b to odd lanes.
module lps_interleave #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              hi,
  output logic [DATA_W-1:0] y
);
  localparam int HALF = DATA_W / 2;
  localparam int NL   = HALF / LANE_W;

  logic [HALF-1:0] ha;
  logic [HALF-1:0] hb;

  assign ha = hi ? a[DATA_W-1:HALF] : a[HALF-1:0];
  assign hb = hi ? b[DATA_W-1:HALF] : b[HALF-1:0];

  for (genvar i = 0; i < NL; i++) begin : g_pair
    assign y[(2*i)*LANE_W   +: LANE_W] = ha[i*LANE_W +: LANE_W];
    assign y[(2*i+1)*LANE_W +: LANE_W] = hb[i*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/lane_pack_unit.sv
`timescale 1ns/1ps
module lane_pack_unit
  import lps_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_err
);
  localparam int NGRAN = 3;   // 8, 16 and 32-bit interleave

  logic [DATA_W-1:0]            nrw16;
  logic [DATA_W-1:0]            nrw32;
  logic [NGRAN-1:0][DATA_W-1:0] ilv;
  logic                         take_hi;

  logic [DATA_W-1:0] res_nx;
  logic              err_nx;
  logic              vld_q;
  logic              err_q;
  logic [DATA_W-1:0] data_q;

  assign take_hi = (op == OP_ILV_HI8) || (op == OP_ILV_HI16) || (op == OP_ILV_HI32);

  lps_narrow #(.DATA_W(DATA_W), .IN_W(16)) u_nrw16 (
    .a (src_a), .b (src_b), .uns (op == OP_NRW_U16), .y (nrw16)
  );

  lps_narrow #(.DATA_W(DATA_W), .IN_W(32)) u_nrw32 (
    .a (src_a), .b (src_b), .uns (op == OP_NRW_U32), .y (nrw32)
  );

  for (genvar g = 0; g < NGRAN; g++) begin : g_ilv
    lps_interleave #(.DATA_W(DATA_W), .LANE_W(8 << g)) u_ilv (
      .a (src_a), .b (src_b), .hi (take_hi), .y (ilv[g])
    );
  end

  // Next-state selection
  always_comb begin
    res_nx = '0;
    err_nx = 1'b0;
    case (op)
      OP_NRW_S16, OP_NRW_U16:  res_nx = nrw16;
      OP_NRW_S32, OP_NRW_U32:  res_nx = nrw32;
      OP_ILV_LO8, OP_ILV_HI8:  res_nx = ilv[0];
      OP_ILV_LO16, OP_ILV_HI16: res_nx = ilv[1];
      OP_ILV_LO32, OP_ILV_HI32: res_nx = ilv[2];
      default:                 err_nx = 1'b1;
    endcase
  end

  // Registers; rst_n is assumed deasserted synchronously upstream.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q <= in_valid;
      err_q <= in_valid & err_nx;
      if (in_valid) begin
        data_q <= res_nx;
      end
    end
  end

  assign out_valid = vld_q;
  assign out_err   = err_q;
  assign out_data  = data_q;
endmodule

// File: rtl/lps_checker.sv
`timescale 1ns/1ps
module lps_checker
  import lps_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [OP_W-1:0]   op,
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] src_b,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_err
);
  localparam int HALF = DATA_W / 2;

  p_valid_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_sat_pos_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_NRW_S16 && !src_a[15] && src_a[14:7] != 8'h00)
    |=> out_data[7:0] == 8'h7F);

  p_neg_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_NRW_U16 && src_a[15]) |=> out_data[7:0] == 8'h00);

  p_lo_dword_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_ILV_LO32)
    |=> out_data == {$past(src_b[HALF-1:0]), $past(src_a[HALF-1:0])});

  p_hi_dword_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_ILV_HI32)
    |=> out_data == {$past(src_b[DATA_W-1:HALF]), $past(src_a[DATA_W-1:HALF])});

  p_bad_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op > OP_LAST_VALID) |=> (out_err && out_data == '0));

  p_good_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op <= OP_LAST_VALID) |=> !out_err);

  p_err_has_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_data) && !out_err));
endmodule

bind lane_pack_unit lps_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op        (op),
  .src_a     (src_a),
  .src_b     (src_b),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_err   (out_err)
);

// File: tb/lane_pack_unit_test.sv
`timescale 1ns/1ps
module lane_pack_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  op;
  logic [63:0] src_a;
  logic [63:0] src_b;
  logic        out_valid;
  logic [63:0] out_data;
  logic        out_err;

  int n_chk = 0;
  int n_fail = 0;

  logic [63:0] exp_data;

  always #2.5 clk = ~clk;

  lane_pack_unit uut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .op (op),
    .src_a (src_a), .src_b (src_b),
    .out_valid (out_valid), .out_data (out_data), .out_err (out_err)
  );

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2: return "R4";
      4'd3: return "R5";
      4'd4, 4'd5, 4'd6: return "R6";
      4'd7, 4'd8, 4'd9: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic int clampi(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  // Behavioural reference built from the requirements.
  function automatic logic [63:0] model(input logic [3:0] o, input logic [63:0] a,
                                        input logic [63:0] b, output bit bad);
    logic [63:0] r;
    r = '0;
    bad = 1'b0;
    if (o == 4'd0 || o == 4'd1) begin
      for (int i = 0; i < 8; i++) begin
        logic signed [15:0] s;
        int v;
        s = (i < 4) ? a[16*i +: 16] : b[16*(i-4) +: 16];
        v = s;
        v = (o == 4'd1) ? clampi(v, 0, 255) : clampi(v, -128, 127);
        r[8*i +: 8] = v[7:0];
      end
    end else if (o == 4'd2 || o == 4'd3) begin
      for (int i = 0; i < 4; i++) begin
        logic signed [31:0] s;
        longint v;
        s = (i < 2) ? a[32*i +: 32] : b[32*(i-2) +: 32];
        v = s;
        if (o == 4'd3) v = (v < 0) ? 0 : ((v > 65535) ? 65535 : v);
        else           v = (v < -32768) ? -32768 : ((v > 32767) ? 32767 : v);
        r[16*i +: 16] = v[15:0];
      end
    end else if (o >= 4'd4 && o <= 4'd9) begin
      int w;
      int base;
      w = 8 << ((o - 4) % 3);
      base = (o >= 4'd7) ? 32 : 0;
      for (int i = 0; i < 32 / w; i++) begin
        for (int k = 0; k < w; k++) begin
          r[2*i*w + k]     = a[base + i*w + k];
          r[(2*i+1)*w + k] = b[base + i*w + k];
        end
      end
    end else begin
      bad = 1'b1;
    end
    return r;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Drive at a falling edge, check at the next falling edge.
  task automatic step(input logic v, input logic [3:0] o,
                      input logic [63:0] a, input logic [63:0] b);
    bit bad;
    logic [63:0] m;
    in_valid = v; op = o; src_a = a; src_b = b;
    m = model(o, a, b, bad);
    if (v) exp_data = m;
    @(negedge clk);
    check("R1", "out_valid", {63'd0, out_valid}, {63'd0, v});
    if (v) begin
      check(bad ? "R8" : tag_of(o), "out_err", {63'd0, out_err}, {63'd0, bad});
      check(tag_of(o), "out_data", out_data, exp_data);
    end else begin
      check("R9", "out_err", {63'd0, out_err}, 64'd0);
      check("R9", "out_data hold", out_data, exp_data);
    end
  endtask

  function automatic logic [15:0] edge16(input int sel);
    case (sel % 8)
      0: return 16'h7FFF;
      1: return 16'h8000;
      2: return 16'h007F;
      3: return 16'h0080;
      4: return 16'hFF80;
      5: return 16'hFF7F;
      6: return 16'h00FF;
      default: return 16'h0100;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op = '0; src_a = '0; src_b = '0;
    exp_data = '0;
    repeat (3) @(negedge clk);
    check("R1", "reset out_valid", {63'd0, out_valid}, 64'd0);
    check("R1", "reset out_err", {63'd0, out_err}, 64'd0);
    check("R1", "reset out_data", out_data, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3: byte narrowing around both clamp limits
    step(1'b1, 4'd0, 64'h7FFF_0080_FF80_8000, 64'h007F_FF7F_0000_FFFF);
    step(1'b1, 4'd1, 64'h7FFF_0080_FF80_8000, 64'h00FF_0100_0000_FFFF);
    // R4/R5: 16-bit narrowing
    step(1'b1, 4'd2, 64'h0000_8000_FFFF_7FFF, 64'h7FFF_FFFF_8000_0000);
    step(1'b1, 4'd3, 64'h0000_FFFF_0001_0000, 64'hFFFF_FFFF_0000_1234);
    // R6/R7: every interleave granularity
    for (int o = 4; o <= 9; o++)
      step(1'b1, 4'(o), 64'h0706_0504_0302_0100, 64'hF7F6_F5F4_F3F2_F1F0);
    // R8: unsupported opcode, then a supported one clears the flag
    step(1'b1, 4'd12, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0);
    step(1'b1, 4'd5, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888);
    // R9: idle cycles with changing inputs
    step(1'b0, 4'd0, 64'hDEAD_BEEF_DEAD_BEEF, 64'h0);
    step(1'b0, 4'd14, 64'h0, 64'hCAFE_CAFE_CAFE_CAFE);

    for (int n = 0; n < 400; n++) begin
      logic [63:0] a;
      logic [63:0] b;
      if (n % 2 == 0) begin
        a = {$urandom, $urandom};
        b = {$urandom, $urandom};
      end else begin
        a = {edge16(n), edge16(n + 3), edge16(n + 5), edge16(n / 3)};
        b = {edge16(n + 1), edge16(n / 5), edge16(n + 6), edge16(n + 2)};
      end
      step(($urandom % 4) != 0, 4'($urandom % 16), a, b);
    end

    // R1: asynchronous reset mid-run
    step(1'b1, 4'd7, 64'hAAAA_BBBB_CCCC_DDDD, 64'h1);
    #1 rst_n = 1'b0;
    #0.5;
    check("R1", "async reset out_valid", {63'd0, out_valid}, 64'd0);
    check("R1", "async reset out_data", out_data, 64'd0);
    exp_data = '0;
    @(negedge clk);
    rst_n = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    step(1'b1, 4'd1, 64'h8000_7FFF_0100_00FF, 64'h0);

    summary();
    $finish;
  end
endmodule